// File: doc/BRIEF.md
# SEC-DED Protected Register File

This block is a flip-flop register file of 32 words of 32 bits. Every word is held as a 39-bit codeword: six Hamming check bits and one overall parity bit are kept next to the 32 data bits. A write encodes the incoming word. A read decodes the stored codeword, repairs a single flipped bit on the fly, and returns the data with a two-bit integrity status. The status says whether the word was clean, was corrected, or could not be trusted. When three or more bits of one codeword are flipped, the status is not guaranteed to be right.

The storage is split into four banks of eight words. A read, a write and a debug access may each target a different bank in the same cycle. A per-write mode bit selects whether a word is stored protected or raw. A debug port shows the raw codeword of any word and can invert any single stored bit, so that fault-injection experiments can be run against the decoder.

Top module: `secded_regfile`

## Requirements
- R1: After reset every word holds data zero, is protected, and reads back as data 0 with status 2'b00.
- R2: A read strobe in cycle t gives `rd_data`, `rd_status` and a one-cycle `rd_valid` pulse after the clock edge that ends cycle t. A protected word read back unaltered returns the written data with status 2'b00 (clean).
- R3: `reg_idx[4:3]` selects one of four banks and `reg_idx[2:0]` selects the word inside it. All 32 words hold independent values.
- R4: Codeword bit p is Hamming position p. Bit 0 is the overall even parity of bits 38..1. Bits 1, 2, 4, 8, 16 and 32 are the check bits. Data bits 0..31 fill the remaining positions 3..38 in ascending order. `dbg_word` shows the raw stored codeword of word `dbg_idx`.
- R5: When exactly one bit (any of positions 0..38) of a protected word is flipped, a read returns the original data with status 2'b01 (corrected).
- R6: When exactly two bits of a protected word are flipped, a read reports status 2'b10 (uncorrectable).
- R7: A corrected value is never written back. A repeated read of the same faulty word reports 2'b01 again, and the stored codeword keeps the flipped bit until the next write.
- R8: A write with `prot_en`=0 stores the data bits at their R4 positions with all check and parity bits zero. Reads of such a word return the raw data positions with status 2'b00, whatever bits have been flipped.
- R9: A `dbg_flip` pulse inverts stored bit `dbg_pos` of word `dbg_idx`. A position of 39 or more is ignored. A write to the same word in the same cycle takes priority over the flip.
- R10: A read and a write to the same word in the same cycle return the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| prot_en | input | 1 | Write mode: 1 protected, 0 raw |
| reg_idx | input | 5 | Word index for read and write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| rd_status | output | 2 | 00 clean, 01 corrected, 10 uncorrectable |
| rd_valid | output | 1 | High for one cycle when read results are valid |
| dbg_idx | input | 5 | Word index for the debug port |
| dbg_pos | input | 6 | Codeword bit to invert |
| dbg_flip | input | 1 | Invert strobe |
| dbg_word | output | 39 | Raw stored codeword of word dbg_idx |

## Verification
The bench injects single faults at the parity bit, at check bits and at the outermost data position. A decoder that mishandles syndrome zero with odd parity, or that maps positions wrongly, would return the wrong data or a wrong status for these words. Double faults must give the uncorrectable code, not a false repair. Repeated reads of a faulty word would expose a design that silently writes the corrected value back. Raw-mode words, out-of-range flip positions, a flip colliding with a write, and a read colliding with a write are checked, because a wrong priority would change stored bits or the returned data.

// File: rtl/secded_pkg.sv
package secded_pkg;
   localparam int DATA_W = 32;
   localparam int HAM_W  = 6;
   localparam int CW_W   = DATA_W + HAM_W + 1;

   typedef logic [CW_W-1:0]   cw_t;
   typedef logic [DATA_W-1:0] word_t;

   typedef enum logic [1:0] {
      ST_CLEAN = 2'b00,
      ST_FIXED = 2'b01,
      ST_BAD   = 2'b10
   } status_e;

   function automatic bit is_pow2(input int p);
      return (p > 0) && ((p & (p - 1)) == 0);
   endfunction

   // Hamming position holding data bit i
   function automatic int data_pos(input int i);
      int cnt;
      cnt = 0;
      for (int p = 1; p < CW_W; p++) begin
         if (!is_pow2(p)) begin
            if (cnt == i) return p;
            cnt++;
         end
      end
      return 0;
   endfunction
endpackage

// File: rtl/secded_enc.sv
module secded_enc
   import secded_pkg::*;
(
   input  word_t data_i,
   input  logic  prot_i,
   output cw_t   cw_o
);
   always_comb begin
      cw_o = '0;
      for (int i = 0; i < DATA_W; i++) begin
         cw_o[data_pos(i)] = data_i[i];
      end
      if (prot_i) begin
         for (int k = 0; k < HAM_W; k++) begin
            for (int p = 1; p < CW_W; p++) begin
               if (!is_pow2(p) && (((p >> k) & 1) == 1)) begin
                  cw_o[1 << k] = cw_o[1 << k] ^ cw_o[p];
               end
            end
         end
         cw_o[0] = ^cw_o[CW_W-1:1];
      end
   end
endmodule

// File: rtl/secded_dec.sv
module secded_dec
   import secded_pkg::*;
(
   input  cw_t     cw_i,
   input  logic    prot_i,
   output word_t   data_o,
   output status_e status_o
);
   logic [HAM_W-1:0] syn;
   logic             par;
   cw_t              fixed;

   always_comb begin
      syn = '0;
      for (int p = 1; p < CW_W; p++) begin
         if (cw_i[p]) syn = syn ^ HAM_W'(p);
      end
      par      = ^cw_i;
      fixed    = cw_i;
      status_o = ST_CLEAN;
      if (prot_i) begin
         if (par) begin
            if (int'(syn) < CW_W) begin
               fixed[syn] = ~fixed[syn];
               status_o   = ST_FIXED;
            end else begin
               status_o   = ST_BAD;
            end
         end else if (syn != '0) begin
            status_o = ST_BAD;
         end
      end
      for (int i = 0; i < DATA_W; i++) begin
         data_o[i] = fixed[data_pos(i)];
      end
   end
endmodule

// File: rtl/rf_bank.sv
module rf_bank
   import secded_pkg::*;
#(
   parameter int DEPTH = 8,
   localparam int LOC_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [LOC_W-1:0] wr_loc,
   input  cw_t              wr_cw,
   input  logic             wr_prot,
   input  logic             flip_en,
   input  logic [LOC_W-1:0] flip_loc,
   input  logic [5:0]       flip_pos,
   input  logic [LOC_W-1:0] rd_loc,
   output cw_t              rd_cw,
   output logic             rd_prot,
   input  logic [LOC_W-1:0] dbg_loc,
   output cw_t              dbg_cw
);
   cw_t              mem [DEPTH];
   logic [DEPTH-1:0] prot_q;
   logic             flip_ok;

   assign flip_ok = flip_en && (int'(flip_pos) < CW_W)
                    && !(wr_en && (wr_loc == flip_loc));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         prot_q <= '1;
      end else begin
         if (flip_ok) mem[flip_loc][flip_pos] <= ~mem[flip_loc][flip_pos];
         if (wr_en) begin
            mem[wr_loc]    <= wr_cw;
            prot_q[wr_loc] <= wr_prot;
         end
      end
   end

   assign rd_cw   = mem[rd_loc];
   assign rd_prot = prot_q[rd_loc];
   assign dbg_cw  = mem[dbg_loc];

   p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> mem[$past(wr_loc)] == $past(wr_cw));

   p_flip_single_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (flip_en && int'(flip_pos) < CW_W && !(wr_en && wr_loc == flip_loc))
      |=> $countones(mem[$past(flip_loc)] ^ $past(mem[flip_loc])) == 1);

   p_oob_flip_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (flip_en && int'(flip_pos) >= CW_W && !(wr_en && wr_loc == flip_loc))
      |=> mem[$past(flip_loc)] == $past(mem[flip_loc]));
endmodule

// File: rtl/secded_regfile.sv
module secded_regfile
   import secded_pkg::*;
#(
   parameter int NUM_WORDS = 32,
   parameter int NUM_BANKS = 4,
   localparam int IDX_W  = $clog2(NUM_WORDS),
   localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int DEPTH  = NUM_WORDS / NUM_BANKS,
   localparam int LOC_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic              prot_en,
   input  logic [IDX_W-1:0]  reg_idx,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic [1:0]        rd_status,
   output logic              rd_valid,
   input  logic [IDX_W-1:0]  dbg_idx,
   input  logic [5:0]        dbg_pos,
   input  logic              dbg_flip,
   output logic [CW_W-1:0]   dbg_word
);
   if (NUM_WORDS != (1 << IDX_W)) begin : g_bad_words
      $error("NUM_WORDS must be a power of two");
   end
   if (NUM_BANKS < 2 || NUM_BANKS != (1 << BANK_W) || DEPTH < 2) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two giving at least two words per bank");
   end
   if ((1 << HAM_W) < CW_W) begin : g_bad_code
      $error("too few check bits for the data width");
   end

   localparam int LO = LOC_W;

   logic [BANK_W-1:0] acc_bank, dbg_bank;
   logic [LOC_W-1:0]  acc_loc, dbg_loc;
   cw_t               enc_cw;
   cw_t               bank_rd_cw  [NUM_BANKS];
   cw_t               bank_dbg_cw [NUM_BANKS];
   logic [NUM_BANKS-1:0] bank_rd_prot;
   cw_t               sel_cw;
   logic              sel_prot;
   word_t             dec_data;
   status_e           dec_status;

   assign acc_bank = reg_idx[IDX_W-1:LO];
   assign acc_loc  = reg_idx[LO-1:0];
   assign dbg_bank = dbg_idx[IDX_W-1:LO];
   assign dbg_loc  = dbg_idx[LO-1:0];

   secded_enc u_enc (
      .data_i (wr_data),
      .prot_i (prot_en),
      .cw_o   (enc_cw)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      rf_bank #(.DEPTH(DEPTH)) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (wr_en && (acc_bank == BANK_W'(b))),
         .wr_loc   (acc_loc),
         .wr_cw    (enc_cw),
         .wr_prot  (prot_en),
         .flip_en  (dbg_flip && (dbg_bank == BANK_W'(b))),
         .flip_loc (dbg_loc),
         .flip_pos (dbg_pos),
         .rd_loc   (acc_loc),
         .rd_cw    (bank_rd_cw[b]),
         .rd_prot  (bank_rd_prot[b]),
         .dbg_loc  (dbg_loc),
         .dbg_cw   (bank_dbg_cw[b])
      );
   end

   assign sel_cw   = bank_rd_cw[acc_bank];
   assign sel_prot = bank_rd_prot[acc_bank];
   assign dbg_word = bank_dbg_cw[dbg_bank];

   secded_dec u_dec (
      .cw_i     (sel_cw),
      .prot_i   (sel_prot),
      .data_o   (dec_data),
      .status_o (dec_status)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data   <= '0;
         rd_status <= ST_CLEAN;
         rd_valid  <= 1'b0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) begin
            rd_data   <= dec_data;
            rd_status <= dec_status;
         end
      end
   end

   p_read_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);

   p_valid_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rd_valid);

   p_status_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> rd_status != 2'b11);

   p_raw_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !sel_prot) |=> rd_status == ST_CLEAN);
endmodule

// File: tb/secded_regfile_tb.sv
`timescale 1ns/1ps
module secded_regfile_tb;
   logic        clk = 0;
   logic        rst_n = 0;
   logic        rd_en = 0, wr_en = 0, prot_en = 1;
   logic [4:0]  reg_idx = 0;
   logic [31:0] wr_data = 0;
   logic [31:0] rd_data;
   logic [1:0]  rd_status;
   logic        rd_valid;
   logic [4:0]  dbg_idx = 0;
   logic [5:0]  dbg_pos = 0;
   logic        dbg_flip = 0;
   logic [38:0] dbg_word;

   int checks = 0, failures = 0, cycles = 0;

   always #4 clk = ~clk;

   secded_regfile u_dut (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .prot_en(prot_en),
      .reg_idx(reg_idx), .wr_data(wr_data), .rd_data(rd_data), .rd_status(rd_status),
      .rd_valid(rd_valid), .dbg_idx(dbg_idx), .dbg_pos(dbg_pos), .dbg_flip(dbg_flip),
      .dbg_word(dbg_word)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         failures++;
         $display("FAIL watchdog expired act=%0d exp<=100000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [4:0] i, input logic [31:0] d, input logic p);
      @(negedge clk);
      wr_en = 1; reg_idx = i; wr_data = d; prot_en = p;
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic do_read(input logic [4:0] i, output logic [31:0] d,
                          output logic [1:0] s, output logic v);
      @(negedge clk);
      rd_en = 1; reg_idx = i;
      @(negedge clk);
      rd_en = 0;
      d = rd_data; s = rd_status; v = rd_valid;
   endtask

   task automatic do_flip(input logic [4:0] i, input logic [5:0] pos);
      @(negedge clk);
      dbg_flip = 1; dbg_idx = i; dbg_pos = pos;
      @(negedge clk);
      dbg_flip = 0;
   endtask

   task automatic peek(input logic [4:0] i, output logic [38:0] w);
      @(negedge clk);
      dbg_idx = i;
      #1 w = dbg_word;
   endtask

   typedef struct packed {
      logic [4:0]  idx;
      logic [31:0] data;
      logic        prot;
      logic [5:0]  f1;
      logic [5:0]  f2;
      logic [1:0]  st;
      logic [31:0] exp;
   } vec_t;

   // 63 = no fault (out-of-range position, ignored per R9)
   localparam vec_t VECS [10] = '{
      '{5'd0,  32'hA5A55A5A, 1'b1, 6'd63, 6'd63, 2'b00, 32'hA5A55A5A},
      '{5'd31, 32'hFFFFFFFF, 1'b1, 6'd5,  6'd63, 2'b01, 32'hFFFFFFFF},
      '{5'd9,  32'h12345678, 1'b1, 6'd0,  6'd63, 2'b01, 32'h12345678},
      '{5'd17, 32'hDEADBEEF, 1'b1, 6'd38, 6'd63, 2'b01, 32'hDEADBEEF},
      '{5'd24, 32'h00000000, 1'b1, 6'd16, 6'd63, 2'b01, 32'h00000000},
      '{5'd3,  32'hCAFEF00D, 1'b1, 6'd7,  6'd20, 2'b10, 32'h0},
      '{5'd12, 32'h00000001, 1'b1, 6'd1,  6'd2,  2'b10, 32'h0},
      '{5'd20, 32'h00000001, 1'b0, 6'd3,  6'd63, 2'b00, 32'h00000000},
      '{5'd27, 32'h80000000, 1'b0, 6'd38, 6'd63, 2'b00, 32'h00000000},
      '{5'd5,  32'h0F0F0F0F, 1'b0, 6'd4,  6'd63, 2'b00, 32'h0F0F0F0F}
   };

   initial begin
      logic [31:0] d;
      logic [1:0]  s;
      logic        v;
      logic [38:0] w, w2;

      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1: reset state
      for (int i = 0; i < 32; i += 13) begin
         do_read(5'(i), d, s, v);
         check("R1 reset data", 64'(d), 64'h0);
         check("R1 reset status", 64'(s), 64'h0);
      end
      @(negedge clk);
      check("R2 valid is one cycle", 64'(rd_valid), 64'h0);

      // Vector table: R2 R5 R6 R8 R9
      foreach (VECS[k]) begin
         do_write(VECS[k].idx, VECS[k].data, VECS[k].prot);
         do_flip(VECS[k].idx, VECS[k].f1);
         do_flip(VECS[k].idx, VECS[k].f2);
         do_read(VECS[k].idx, d, s, v);
         check("R2 rd_valid", 64'(v), 64'h1);
         check("R5/R6/R8 status", 64'(s), 64'(VECS[k].st));
         if (VECS[k].st != 2'b10) check("R5/R8 data", 64'(d), 64'(VECS[k].exp));
      end

      // R4: codeword layout
      do_write(5'd8, 32'h00000001, 1'b1);
      peek(5'd8, w);
      check("R4 protected codeword", 64'(w), 64'hF);
      do_write(5'd8, 32'h00000001, 1'b0);
      peek(5'd8, w);
      check("R8 raw codeword", 64'(w), 64'h8);

      // R7: no write-back
      do_write(5'd14, 32'h55AA33CC, 1'b1);
      peek(5'd14, w);
      do_flip(5'd14, 6'd10);
      do_read(5'd14, d, s, v);
      check("R7 first read status", 64'(s), 64'h1);
      do_read(5'd14, d, s, v);
      check("R7 second read status", 64'(s), 64'h1);
      check("R7 second read data", 64'(d), 64'h55AA33CC);
      peek(5'd14, w2);
      check("R7 stored fault kept", 64'(w ^ w2), 64'h400);

      // R9: out-of-range flip ignored, write wins over flip
      peek(5'd14, w);
      do_flip(5'd14, 6'd39);
      peek(5'd14, w2);
      check("R9 pos 39 ignored", 64'(w2), 64'(w));
      @(negedge clk);
      wr_en = 1; reg_idx = 5'd6; wr_data = 32'h01020304; prot_en = 1;
      dbg_flip = 1; dbg_idx = 5'd6; dbg_pos = 6'd12;
      @(negedge clk);
      wr_en = 0; dbg_flip = 0;
      do_read(5'd6, d, s, v);
      check("R9 write beats flip status", 64'(s), 64'h0);
      check("R9 write beats flip data", 64'(d), 64'h01020304);

      // R10: read-before-write
      @(negedge clk);
      rd_en = 1; wr_en = 1; reg_idx = 5'd6; wr_data = 32'hBEEF0001; prot_en = 1;
      @(negedge clk);
      rd_en = 0; wr_en = 0;
      check("R10 old data", 64'(rd_data), 64'h01020304);
      do_read(5'd6, d, s, v);
      check("R10 new data", 64'(d), 64'hBEEF0001);

      // R3: all words independent across banks
      for (int i = 0; i < 32; i++) do_write(5'(i), 32'h1000_0000 + 32'(i * 7), 1'b1);
      for (int i = 0; i < 32; i++) begin
         do_read(5'(i), d, s, v);
         check("R3 word data", 64'(d), 64'(32'h1000_0000 + 32'(i * 7)));
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule